// File: doc/BRIEF.md
# Carry-Select Adder with Excess-One Incrementer Groups

This block is a combinational adder of parameterized width. It adds two unsigned operands and a carry-in, and it returns a sum of the same width and a carry-out. The word is split into 4-bit groups. The lowest group is a plain ripple-carry adder fed by the external carry-in.

Each higher group has a single ripple-carry adder whose carry-in is tied to zero. The group's result for an incoming carry of one is that zero-carry result, carry bit included, plus one. A 5-bit incrementer produces it, so no second adder is needed. Every bit of the incrementer uses an inverter and a 2:1 multiplexer instead of an XOR. A running AND of the lower bits selects between the bit and its inverse. A multiplexer in each group then picks the direct result or the incremented one, steered by the carry chosen in the group below. The carry chosen in the top group drives the adder's carry-out.

The adder sits on a datapath wherever fast addition is needed at modest area. It has no clock and no state.

Top module: `csel_adder`

## Requirements
- R1: For every operand pair and carry-in, {cout_o, sum_o} equals a_i + b_i + cin_i as an unsigned sum of WIDTH+1 bits. WIDTH is a multiple of 4, and both 8 and 16 are supported.
- R2: The lowest 4-bit group adds with the external carry-in, so a_i = 0, b_i = 0, cin_i = 1 gives sum_o = 1 and cout_o = 0.
- R3: The incremented group result wraps across its 5 bits (4 sum bits plus the group carry). With all-ones operands and cin_i = 1, sum_o is all ones and cout_o = 1.
- R4: An upper group outputs its zero-carry sum when the carry from the group below is 0, and that sum plus one when the carry is 1. In 8-bit terms, 0x0F + 0x01 gives 0x10 and 0x10 + 0x20 gives 0x30.
- R5: A carry entering the lowest group propagates through every group. With a_i all ones, b_i = 0 and cin_i = 1, the result is sum_o = 0 and cout_o = 1.
- R6: cout_o is the carry selected in the top group. With only the MSB set in both operands and cin_i = 0, the result is sum_o = 0 and cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into the lowest group |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top group |

## Verification
The bench builds two copies of the adder side by side, one with WIDTH = 8 and one with WIDTH = 16. At 8 bits it covers every operand pair with both carry-in values, which exercises every select pattern of the single upper group and every incrementer wrap. The 16-bit copy receives random operands and directed corner cases, such as all-ones operands with carry-in 1. These corner cases push a carry through all four groups and the three select multiplexers.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int unsigned GRP_W = 4;

  function automatic int unsigned num_groups(input int unsigned width);
    return width / GRP_W;
  endfunction
endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         ci_i,
  output logic [N-1:0] s_o,
  output logic         co_o
);
  logic [N:0] c;
  assign c[0] = ci_i;

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign s_o[i]  = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]  = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign co_o = c[N];

  always_comb begin
    if (!$isunknown({a_i, b_i, ci_i}))
      AST_RIPPLE_SUM: assert ({co_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, ci_i})) // R2
        else $error("ripple group sum mismatch");
  end
endmodule

// File: rtl/csel_inc.sv
module csel_inc #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  // run[i]: all bits below i are one
  logic [N-1:0] run;
  assign run[0] = 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic inv;
    assign inv    = ~d_i[i];
    assign q_o[i] = run[i] ? inv : d_i[i];
    if (i > 0) begin : g_run
      assign run[i] = run[i-1] & d_i[i-1];
    end
  end

  always_comb begin
    if (!$isunknown(d_i))
      AST_INC_PLUS_ONE: assert (q_o == N'(d_i + 1'b1)) // R3
        else $error("incrementer mismatch");
  end
endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         sel_i,
  output logic [N-1:0] s_o,
  output logic         co_o
);
  logic [N-1:0] s0;
  logic         c0;
  logic [N:0]   inc;

  csel_ripple #(.N(N)) u_rca (
    .a_i (a_i),
    .b_i (b_i),
    .ci_i(1'b0),
    .s_o (s0),
    .co_o(c0)
  );

  csel_inc #(.N(N+1)) u_inc (
    .d_i({c0, s0}),
    .q_o(inc)
  );

  assign {co_o, s_o} = sel_i ? inc : {c0, s0};

  always_comb begin
    if (!$isunknown({a_i, b_i, sel_i}))
      AST_GROUP_SELECT: assert ({co_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, sel_i})) // R4
        else $error("group select mismatch");
  end
endmodule

// File: rtl/csel_adder.sv
module csel_adder
  import csel_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned NG = num_groups(WIDTH);

  logic [NG:0] carry;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int unsigned LO = g * GRP_W;
    if (g == 0) begin : g_low
      csel_ripple #(.N(GRP_W)) u_low (
        .a_i (a_i[LO +: GRP_W]),
        .b_i (b_i[LO +: GRP_W]),
        .ci_i(cin_i),
        .s_o (sum_o[LO +: GRP_W]),
        .co_o(carry[1])
      );
    end else begin : g_up
      csel_group #(.N(GRP_W)) u_up (
        .a_i  (a_i[LO +: GRP_W]),
        .b_i  (b_i[LO +: GRP_W]),
        .sel_i(carry[g]),
        .s_o  (sum_o[LO +: GRP_W]),
        .co_o (carry[g+1])
      );
    end
  end

  assign carry[0] = cin_i;
  assign cout_o   = carry[NG];

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      AST_TOTAL_SUM: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})) // R1
        else $error("adder total mismatch");
      if ((&a_i) && (b_i == '0) && cin_i)
        AST_FULL_PROPAGATE: assert ((sum_o == '0) && cout_o) // R5
          else $error("carry did not propagate");
      if ((a_i == b_i) && (a_i == {1'b1, {(WIDTH-1){1'b0}}}) && !cin_i)
        AST_TOP_CARRY: assert (cout_o && (sum_o == '0)) // R6
          else $error("top carry wrong");
    end
  end
endmodule

// File: tb/tb_csel_adder.sv
module tb_csel_adder;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;

  typedef struct {
    logic [15:0] a16, b16; logic c16;
    logic [7:0]  a8, b8;   logic c8;
    logic [16:0] exp16;
    logic [8:0]  exp8;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        c16 = 1'b0, co16;
  logic [7:0]  a8 = '0, b8 = '0, s8;
  logic        c8 = 1'b0, co8;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t q[$];

  csel_adder #(.WIDTH(16)) dut (
    .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16)
  );
  csel_adder #(.WIDTH(8)) dut_w8 (
    .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8)
  );

  task automatic drive(input logic [15:0] xa16, input logic [15:0] xb16, input logic xc16,
                       input logic [7:0] xa8, input logic [7:0] xb8, input logic xc8,
                       input string tag);
    item_t it;
    @(posedge clk);
    a16 <= xa16; b16 <= xb16; c16 <= xc16;
    a8  <= xa8;  b8  <= xb8;  c8  <= xc8;
    it.a16 = xa16; it.b16 = xb16; it.c16 = xc16;
    it.a8  = xa8;  it.b8  = xb8;  it.c8  = xc8;
    it.exp16 = {1'b0, xa16} + {1'b0, xb16} + {16'd0, xc16};
    it.exp8  = {1'b0, xa8} + {1'b0, xb8} + {8'd0, xc8};
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare half a cycle after inputs change
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if ({co16, s16} !== it.exp16) begin
          fails++;
          $display("FAIL %s w16 a=%h b=%h c=%b actual=%h expected=%h",
                   it.tag, it.a16, it.b16, it.c16, {co16, s16}, it.exp16);
        end
        checks++;
        if ({co8, s8} !== it.exp8) begin
          fails++;
          $display("FAIL %s w8 a=%h b=%h c=%b actual=%h expected=%h",
                   it.tag, it.a8, it.b8, it.c8, {co8, s8}, it.exp8);
        end
      end
    end
  end

  initial begin
    for (int n = 0; n < WATCHDOG; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset-state equivalent: zero inputs give zero result (R1)
    drive(16'h0000, 16'h0000, 1'b0, 8'h00, 8'h00, 1'b0, "R1_zero");
    drive(16'h0000, 16'h0000, 1'b1, 8'h00, 8'h00, 1'b1, "R2");
    drive(16'hFFFF, 16'hFFFF, 1'b1, 8'hFF, 8'hFF, 1'b1, "R3");
    drive(16'h000F, 16'h0001, 1'b0, 8'h0F, 8'h01, 1'b0, "R4_sel1");
    drive(16'h0010, 16'h0020, 1'b0, 8'h10, 8'h20, 1'b0, "R4_sel0");
    drive(16'hFFFF, 16'h0000, 1'b1, 8'hFF, 8'h00, 1'b1, "R5");
    drive(16'h8000, 16'h8000, 1'b0, 8'h80, 8'h80, 1'b0, "R6");
    drive(16'h0FFF, 16'h0000, 1'b1, 8'h0F, 8'h00, 1'b1, "R5_part");
    // exhaustive 8-bit, random 16-bit (R1)
    for (int x = 0; x < 131072; x++) begin
      logic [16:0] v;
      logic [31:0] r;
      v = 17'(x);
      r = $urandom;
      drive(r[15:0], r[31:16], r[0] ^ r[17], v[7:0], v[15:8], v[16], "R1");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule